// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This unit takes two 32-bit binary floating-point words and returns their sum or difference. The result is packed in the same 32-bit format and rounded to nearest with ties to even. A select input flips the sign of the second operand, which turns an add into a subtract. The result and two flags are registered, so a request presented with its strobe appears one cycle later with an output strobe. The outputs hold their value on idle cycles.

Inside, the unit orders the operands by magnitude and aligns the smaller one to the larger exponent. Guard, round and sticky bits are kept through this alignment. It then adds or subtracts the significands and normalizes right by one or left by the count of leading zeros. Rounding follows, with a second normalization when rounding carries out. Zero, infinity and NaN operands are resolved ahead of the numeric path. Subnormal operands are flushed to zero, and results too small to normalize are flushed as well. Both cases are reported on the underflow flag.

Top module: `fp_addsub`

## Requirements
- R1: After reset `out_valid`, `result`, `overflow` and `underflow` are all 0. When `in_valid` is high, the result and flags for that request appear on the next clock edge with `out_valid` high. A cycle with `in_valid` low drops `out_valid`, and `result` and the flags keep their previous values.
- R2: Word layout: bit 31 is the sign (1 = negative), bits 30:23 are the exponent biased by 127, and bits 22:0 are the fraction, with a hidden leading 1 when the exponent is 1..254. With `sub_sel` = 1 the unit returns `op_a - op_b`; with `sub_sel` = 0 it returns `op_a + op_b`.
- R3: The operand of smaller magnitude is shifted right by the exponent difference. Every bit shifted past the round position is ORed into a sticky bit. When the difference is 26 or more, the whole smaller significand ends up in the sticky bit.
- R4: A carry out of a significand addition shifts the sum right by one and raises the exponent by one.
- R5: A subtraction is normalized by shifting left by the number of leading zeros and lowering the exponent by that count. The result sign is the effective sign of the larger-magnitude operand.
- R6: Rounding is to nearest even, using the round bit R (the first bit below the fraction LSB) and the sticky bit S (the OR of all bits below R). RS=00 or 01 truncates, RS=11 increments, and RS=10 increments only when the fraction LSB is 1.
- R7: When rounding carries out of an all-ones significand, the result becomes 1.0 times 2 to the next higher exponent.
- R8: An exact zero sum is +0 (0x00000000), except when both effective operands are negative zeros, in which case it is -0 (0x80000000).
- R9: A finite result whose exponent reaches 255 is returned as a signed infinity (exponent 255, fraction 0) with `overflow` = 1.
- R10: A subnormal operand (exponent 0, fraction nonzero) is used as zero and sets `underflow` = 1. A finite result whose exponent after normalization is below 1 is returned as a zero carrying the result sign, with `underflow` = 1. `overflow` and `underflow` are never both 1.
- R11: If either operand is a NaN (exponent 255, fraction nonzero), the result is the quiet NaN 0x7FC00000 with both flags 0.
- R12: Two infinities of opposite effective sign give 0x7FC00000. Otherwise an infinite operand gives an infinity with that operand's effective sign. In all of these cases both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operands are taken on this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1 = subtract `op_b` from `op_a`, 0 = add |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Rounded packed result |
| overflow | output | 1 | Finite result was too large and became infinity |
| underflow | output | 1 | Subnormal input was flushed, or the result was too small and flushed to zero |

## Verification
The bound checker watches several things on every cycle. It checks the one-cycle strobe timing and that outputs hold while idle. It checks that an overflow always carries an infinity pattern, that any NaN on the output is the canonical quiet NaN, and that the two flags are exclusive. It also checks that a NaN or subnormal operand always yields the expected result and flag one cycle later. The arithmetic itself can only be shown by the bench's directed scenarios. These cover tie handling with odd and even LSB, sticky collapse at large exponent gaps, multi-bit left normalization, round-carry renormalization and the signed-zero rules, each with a precomputed expected word.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int GRS_W   = 3;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MAN_W   = FRAC_W + 1;
    localparam int EXT_W   = MAN_W + GRS_W;
    localparam int EXPI_W  = EXP_W + 2;
    localparam int LZ_W    = $clog2(EXT_W);
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic                sign;
        logic [EXP_W-1:0]    exp;
        logic [FRAC_W-1:0]   frac;
    } fp_word_t;

    typedef struct packed {
        logic nan_any;
        logic inf_clash;
        logic inf_any;
        logic inf_sign;
        logic den_any;
    } fp_class_t;

    typedef struct packed {
        logic                vld;
        logic [WORD_W-1:0]   word;
        logic                ovf;
        logic                unf;
    } fpas_state_t;
endpackage

// File: rtl/fpas_align.sv
module fpas_align
    import fpas_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              sub_i,
    output fp_class_t         cls_o,
    output logic              big_sign_o,
    output logic              small_sign_o,
    output logic [EXP_W-1:0]  big_exp_o,
    output logic [EXT_W-1:0]  big_ext_o,
    output logic [EXT_W-1:0]  small_ext_o
);
    fp_word_t wa, wb;
    logic     sb_eff;
    logic     a_top, b_top, a_zexp, b_zexp, a_fz, b_fz, a_ge;
    logic [EXP_W+FRAC_W-1:0] key_a, key_b;
    logic [MAN_W-1:0]        man_a, man_b, man_small;
    logic [EXP_W-1:0]        exp_small, diff, sh;
    logic [2*EXT_W-1:0]      wide;

    assign wa     = a_i;
    assign wb     = b_i;
    assign sb_eff = wb.sign ^ sub_i;

    always_comb begin
        a_top  = (wa.exp == EXP_W'(EXP_MAX));
        b_top  = (wb.exp == EXP_W'(EXP_MAX));
        a_zexp = (wa.exp == '0);
        b_zexp = (wb.exp == '0);
        a_fz   = (wa.frac == '0);
        b_fz   = (wb.frac == '0);

        cls_o.nan_any   = (a_top & ~a_fz) | (b_top & ~b_fz);
        cls_o.inf_any   = (a_top & a_fz) | (b_top & b_fz);
        cls_o.inf_clash = a_top & a_fz & b_top & b_fz & (wa.sign ^ sb_eff);
        cls_o.inf_sign  = (a_top & a_fz) ? wa.sign : sb_eff;
        cls_o.den_any   = (a_zexp & ~a_fz) | (b_zexp & ~b_fz);

        // subnormals are flushed: zero exponent means zero significand
        key_a = {wa.exp, a_zexp ? {FRAC_W{1'b0}} : wa.frac};
        key_b = {wb.exp, b_zexp ? {FRAC_W{1'b0}} : wb.frac};
        man_a = a_zexp ? '0 : {1'b1, wa.frac};
        man_b = b_zexp ? '0 : {1'b1, wb.frac};
        a_ge  = (key_a >= key_b);

        big_sign_o   = a_ge ? wa.sign : sb_eff;
        small_sign_o = a_ge ? sb_eff  : wa.sign;
        big_exp_o    = a_ge ? wa.exp  : wb.exp;
        exp_small    = a_ge ? wb.exp  : wa.exp;
        man_small    = a_ge ? man_b   : man_a;
        big_ext_o    = {a_ge ? man_a : man_b, {GRS_W{1'b0}}};

        diff = big_exp_o - exp_small;
        sh   = (diff > EXP_W'(EXT_W)) ? EXP_W'(EXT_W) : diff;
        wide = {man_small, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> sh;
        small_ext_o = wide[2*EXT_W-1:EXT_W] | {{(EXT_W-1){1'b0}}, |wide[EXT_W-1:0]};
    end
endmodule

// File: rtl/fpas_addnorm.sv
module fpas_addnorm
    import fpas_pkg::*;
(
    input  logic [EXT_W-1:0]         big_ext_i,
    input  logic [EXT_W-1:0]         small_ext_i,
    input  logic                     eff_sub_i,
    input  logic [EXP_W-1:0]         big_exp_i,
    output logic [EXT_W-1:0]         norm_o,
    output logic signed [EXPI_W-1:0] nexp_o,
    output logic                     zero_o
);
    logic [EXT_W:0]   sum;
    logic [LZ_W-1:0]  lz;

    always_comb begin
        sum = eff_sub_i ? ({1'b0, big_ext_i} - {1'b0, small_ext_i})
                        : ({1'b0, big_ext_i} + {1'b0, small_ext_i});
        lz = '0;
        for (int i = 0; i < EXT_W; i++) begin
            if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
        end
        zero_o = (sum == '0);
        if (sum[EXT_W]) begin
            norm_o = {sum[EXT_W:2], sum[1] | sum[0]};
            nexp_o = $signed({2'b00, big_exp_i}) + $signed(EXPI_W'(1));
        end else begin
            norm_o = sum[EXT_W-1:0] << lz;
            nexp_o = $signed({2'b00, big_exp_i})
                   - $signed({{(EXPI_W-LZ_W){1'b0}}, lz});
        end
    end
endmodule

// File: rtl/fpas_round.sv
module fpas_round
    import fpas_pkg::*;
(
    input  logic [EXT_W-1:0]         norm_i,
    input  logic signed [EXPI_W-1:0] nexp_i,
    input  logic                     zero_i,
    input  logic                     res_sign_i,
    input  logic                     zero_sign_i,
    input  fp_class_t                cls_i,
    output logic [WORD_W-1:0]        word_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    logic                     lsb, rb, sb, inc;
    logic [MAN_W:0]           rm;
    logic [MAN_W-1:0]         man;
    logic signed [EXPI_W-1:0] rexp;

    always_comb begin
        lsb = norm_i[GRS_W];
        rb  = norm_i[GRS_W-1];
        sb  = |norm_i[GRS_W-2:0];
        inc = rb & (sb | lsb);
        rm  = {1'b0, norm_i[EXT_W-1:GRS_W]} + (MAN_W+1)'(inc);
        if (rm[MAN_W]) begin
            man  = rm[MAN_W:1];
            rexp = nexp_i + $signed(EXPI_W'(1));
        end else begin
            man  = rm[MAN_W-1:0];
            rexp = nexp_i;
        end

        ovf_o = 1'b0;
        unf_o = cls_i.den_any;
        if (cls_i.nan_any || cls_i.inf_clash) begin
            word_o = QNAN_WORD;
            unf_o  = 1'b0;
        end else if (cls_i.inf_any) begin
            word_o = {cls_i.inf_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            unf_o  = 1'b0;
        end else if (zero_i) begin
            word_o = {zero_sign_i, {(WORD_W-1){1'b0}}};
        end else if (nexp_i < $signed(EXPI_W'(1))) begin
            word_o = {res_sign_i, {(WORD_W-1){1'b0}}};
            unf_o  = 1'b1;
        end else if (rexp >= $signed(EXPI_W'(EXP_MAX))) begin
            word_o = {res_sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_o  = 1'b1;
        end else begin
            word_o = {res_sign_i, rexp[EXP_W-1:0], man[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_sel,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              overflow,
    output logic              underflow
);
    fp_class_t                cls;
    logic                     big_sign, small_sign, zero;
    logic [EXP_W-1:0]         big_exp;
    logic [EXT_W-1:0]         big_ext, small_ext, norm;
    logic signed [EXPI_W-1:0] nexp;
    logic [WORD_W-1:0]        word;
    logic                     ovf, unf;
    fpas_state_t              st_d, st_q;

    fpas_align u_align (
        .a_i(op_a), .b_i(op_b), .sub_i(sub_sel), .cls_o(cls),
        .big_sign_o(big_sign), .small_sign_o(small_sign),
        .big_exp_o(big_exp), .big_ext_o(big_ext), .small_ext_o(small_ext)
    );

    fpas_addnorm u_addnorm (
        .big_ext_i(big_ext), .small_ext_i(small_ext),
        .eff_sub_i(big_sign ^ small_sign), .big_exp_i(big_exp),
        .norm_o(norm), .nexp_o(nexp), .zero_o(zero)
    );

    fpas_round u_round (
        .norm_i(norm), .nexp_i(nexp), .zero_i(zero),
        .res_sign_i(big_sign), .zero_sign_i(big_sign & small_sign),
        .cls_i(cls), .word_o(word), .ovf_o(ovf), .unf_o(unf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word = word;
            st_d.ovf  = ovf;
            st_d.unf  = unf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.word;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;
endmodule

// File: rtl/fpas_chk.sv
module fpas_chk
    import fpas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              sub_sel,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              overflow,
    input logic              underflow
);
    logic a_nan, a_den, b_fin_norm, res_nan;
    assign a_nan      = (&op_a[WORD_W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
    assign a_den      = (op_a[WORD_W-2:FRAC_W] == '0) && (|op_a[FRAC_W-1:0]);
    assign b_fin_norm = (op_b[WORD_W-2:FRAC_W] != '0) && !(&op_b[WORD_W-2:FRAC_W]);
    assign res_nan    = (&result[WORD_W-2:FRAC_W]) && (|result[FRAC_W-1:0]);

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(overflow) && $stable(underflow))); // R1
    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && overflow) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R9
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_nan) |-> (result == QNAN_WORD)); // R11
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(overflow && underflow)); // R10
    AST_NAN_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_nan) |=> (result == QNAN_WORD && !overflow && !underflow)); // R11
    AST_DEN_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_den && b_fin_norm) |=> underflow); // R10
endmodule

bind fp_addsub fpas_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
    .overflow(overflow), .underflow(underflow)
);

// File: tb/fp_addsub_tb.sv
module fp_addsub_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        sub_sel = 1'b0;
    logic        out_valid, overflow, underflow;
    logic [31:0] result;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_addsub dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request; outputs are sampled on the following falling edge
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic [31:0] exp_w,
                          input logic exp_o, input logic exp_u);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {33'd0, out_valid}, 34'd1);
        check(req, {exp_o, exp_u, result} ^ 34'd0, {exp_o, exp_u, exp_w} ^ 34'd0);
        check({req, " flags"}, {32'd0, overflow, underflow}, {32'd0, exp_o, exp_u});
    endtask

    task automatic t_reset();
        check("R1 reset", {out_valid, overflow, result}, 34'd0);
        check("R1 reset unf", {33'd0, underflow}, 34'd0);
    endtask

    task automatic t_basic();
        run_op("R2 1+1", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 0, 0);
        run_op("R2 1.5-0.5", 32'h3FC00000, 32'h3F000000, 1'b1, 32'h3F800000, 0, 0);
        run_op("R5 10.375+(-0.15625)", 32'h41260000, 32'hBE200000, 1'b0, 32'h41238000, 0, 0);
        run_op("R4 0.5+1.5 carry", 32'h3F000000, 32'h3FC00000, 1'b0, 32'h40000000, 0, 0);
        run_op("R5 0.5-1.5 sign", 32'h3F000000, 32'h3FC00000, 1'b1, 32'hBF800000, 0, 0);
        run_op("R5 1-(1-2^-24) lz", 32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 0, 0);
    endtask

    task automatic t_round();
        run_op("R6 tie even lsb0", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 0, 0);
        run_op("R6 tie odd lsb1", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 0, 0);
        run_op("R6 RS=11 inc", 32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 0, 0);
        run_op("R6 RS=01 trunc", 32'h3F800000, 32'h33000000, 1'b0, 32'h3F800000, 0, 0);
        run_op("R3 sticky gap30 add", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 0, 0);
        run_op("R7 sub round carry", 32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 0, 0);
        run_op("R7 add round carry", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 0, 0);
    endtask

    task automatic t_zero();
        run_op("R8 1-1", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 0, 0);
        run_op("R8 -1-(-1)", 32'hBF800000, 32'hBF800000, 1'b1, 32'h00000000, 0, 0);
        run_op("R8 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 0, 0);
        run_op("R8 +0+-0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 0, 0);
        run_op("R8 -0-+0", 32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 0, 0);
    endtask

    task automatic t_limits();
        run_op("R9 max+max", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1, 0);
        run_op("R9 -max-max", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1, 0);
        run_op("R10 denorm in", 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 0, 1);
        run_op("R10 tiny result", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 0, 1);
        run_op("R10 tiny neg result", 32'h80800001, 32'h80800000, 1'b1, 32'h80000000, 0, 1);
    endtask

    task automatic t_special();
        run_op("R11 qnan in", 32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 0, 0);
        run_op("R11 snan in b", 32'h3F800000, 32'hFF800001, 1'b1, 32'h7FC00000, 0, 0);
        run_op("R12 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 0, 0);
        run_op("R12 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 0, 0);
        run_op("R12 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 0, 0);
        run_op("R12 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 0, 0);
    endtask

    task automatic t_hold();
        run_op("R1 setup", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1, 0);
        op_a = 32'h3F800000; op_b = 32'h3F800000;
        repeat (3) @(negedge clk);
        check("R1 idle valid low", {33'd0, out_valid}, 34'd0);
        check("R1 idle hold", {overflow, underflow, result}, {2'b10, 32'h7F800000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_round();
        t_zero();
        t_limits();
        t_special();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule